// File: doc/BRIEF.md
# ADC Conversion Clock Sequencer

This block drives a successive-approximation converter that runs continuously from one system clock. A free-running divider produces a periodic acquisition strobe (`sample_o`), and a second, even divider produces the bit-decision clock (`conv_clk_o`). The converter's busy line arrives asynchronously and passes through a two-flop synchronizer. The bit-decision clock divider is held cleared whenever the synchronized busy is low or the strobe is high. As a result, no clock edge can land on a strobe transition, and each conversion's clock starts from its low phase.

The block counts the rising edges of the bit-decision clock in each conversion. When busy drops, it reports a clean conversion with a one-cycle `done_o` pulse and a wrong edge count with a one-cycle `err_o` pulse. A watchdog starts at each strobe rise. If the conversion has not finished within the configured number of system clocks, the watchdog raises `err_o` and suppresses any later report for that conversion. If a new strobe period begins while a conversion is still busy, that strobe is dropped and a sticky overrun flag is raised.

Top module: `adc_conv_sequencer`

## Requirements
- R1: With `rate_sel`=0, `sample_o` rises once every SAMPLE_PERIOD system clocks (default 128). With `rate_sel`=1 it rises once every 2×SAMPLE_PERIOD clocks (default 256). Each pulse stays high for ACQ_CYCLES clocks (default 16).
- R2: `busy_in` acts only through a two-flop synchronizer. While the synchronized busy is low, `conv_clk_o` stays low and shows no rising edge.
- R3: While running, `conv_clk_o` has a period of CONV_DIV clocks (default 4). It is high for CONV_DIV/2 clocks and never low for less than CONV_DIV/2. Its first rising edge comes 2 + CONV_DIV/2 clocks after `busy_in` is seen high.
- R4: No more than 3 clocks after `busy_in` falls, `conv_clk_o` is low. It makes no further rising edge until `busy_in` rises again. The final high pulse may be cut short.
- R5: `conv_clk_o` is never high while `sample_o` is high, and it is low in the cycle after `sample_o` falls.
- R6: `done_o` pulses high for exactly one cycle after `busy_in` falls, if exactly CONV_BITS (default 17) rising edges of `conv_clk_o` occurred since `busy_in` rose.
- R7: If that edge count is anything other than CONV_BITS, whether fewer or more, `err_o` pulses for one cycle instead and `done_o` stays low. `done_o` and `err_o` are never high together.
- R8: If TIMEOUT_CYCLES (default 12288) clocks pass after a `sample_o` rise without the conversion ending, `err_o` pulses once, exactly TIMEOUT_CYCLES clocks after that rise. The later end of that conversion then produces neither `done_o` nor `err_o`.
- R9: If the synchronized busy is high when a strobe period begins, that `sample_o` pulse is skipped. `overrun_o` then goes high and stays high until reset.
- R10: While `rst_n` is low at a clock edge (synchronous, active low), every output is low afterwards, and `overrun_o` is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_sel | input | 1 | 0: base strobe rate, 1: half rate |
| busy_in | input | 1 | Converter busy, asynchronous |
| sample_o | output | 1 | Acquisition strobe |
| conv_clk_o | output | 1 | Gated bit-decision clock |
| done_o | output | 1 | One-cycle clean-conversion pulse |
| err_o | output | 1 | One-cycle fault pulse (bad edge count or timeout) |
| overrun_o | output | 1 | Sticky skipped-strobe flag |

## Verification
The start of a new strobe period can coincide with a conversion that is still clocking. This collision is what the skip-and-overrun logic must settle. The bench provokes it by holding off busy for 60 clocks after the strobe falls at the fast rate, so the 17-edge conversion straddles the period boundary. It then judges three things: `overrun_o` must be set, the next strobe rise must come a full double period after the previous one, and `done_o` must still report the straddling conversion. A second collision, between the watchdog deadline and a still-running conversion, is provoked by holding busy high indefinitely. The bench then checks that the fault pulse lands exactly on the deadline and that the late end of busy reports nothing.

// File: rtl/adc_seq_pkg.sv
// Shared types for the conversion clock sequencer.
package adc_seq_pkg;

    // Outcome of one conversion as judged by the tracker.
    typedef enum logic [1:0] {
        VERDICT_NONE = 2'd0,
        VERDICT_GOOD = 2'd1,
        VERDICT_BAD  = 2'd2
    } verdict_e;

endpackage

// File: rtl/adc_seq_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes: STAGES >= 2; the input is a slow level (busy), not a pulse.
module adc_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_seq_sample_gen.sv
// Acquisition strobe generator.
// Counts system clocks over a period chosen by rate_sel (base or double).
// At each period start it raises the strobe for ACQ_CYCLES clocks, unless a
// conversion is still busy; in that case the strobe is dropped and a sticky
// overrun flag is set. start_o marks the cycle in which a strobe is issued.
// Assumes: ACQ_CYCLES < BASE_PERIOD; conv_busy is already synchronized.
module adc_seq_sample_gen #(
    parameter int BASE_PERIOD = 128,
    parameter int ACQ_CYCLES  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_sel,
    input  logic conv_busy,
    output logic sample_o,
    output logic start_o,
    output logic overrun_o
);
    localparam int CW = $clog2(2 * BASE_PERIOD);
    localparam logic [CW-1:0] LIM_FAST = CW'(BASE_PERIOD - 1);
    localparam logic [CW-1:0] LIM_SLOW = CW'(2 * BASE_PERIOD - 1);
    localparam logic [CW-1:0] ACQ_LAST = CW'(ACQ_CYCLES - 1);
    localparam int HW = $clog2(ACQ_CYCLES + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic          wrap;
    logic          sample_q;
    logic          overrun_q;

    // Pick the period end; a late switch to the fast rate wraps at once.
    always_comb begin
        limit = rate_sel ? LIM_SLOW : LIM_FAST;
        wrap  = (cnt >= limit);
    end

    // Free-running period counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (wrap) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // Strobe: set at period start when idle, cleared after the acquire window.
    always_ff @(posedge clk) begin
        if (!rst_n)               sample_q <= 1'b0;
        else if (wrap)            sample_q <= ~conv_busy;
        else if (cnt == ACQ_LAST) sample_q <= 1'b0;
    end

    // Sticky overrun when a period begins during a conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)                 overrun_q <= 1'b0;
        else if (wrap && conv_busy) overrun_q <= 1'b1;
    end

    assign start_o   = wrap & ~conv_busy;
    assign sample_o  = sample_q;
    assign overrun_o = overrun_q;

    // Checker state: consecutive high cycles of the strobe.
    logic [HW-1:0] hi_run;
    always_ff @(posedge clk) begin
        if (!rst_n || !sample_q) hi_run <= '0;
        else                     hi_run <= hi_run + 1'b1;
    end

    // R1
    acq_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_q |-> (hi_run < HW'(ACQ_CYCLES)));

    // R9
    skip_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_q) |-> !$past(conv_busy));

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_q |=> overrun_q);
endmodule

// File: rtl/adc_seq_clk_div.sv
// Gated bit-decision clock divider.
// While run is high, the divider produces a clock of DIV system clocks that
// starts in its low phase; it clears at once when run drops, which may cut
// the last high phase short. rise_o flags the cycle before a rising edge.
// Assumes: DIV is even and at least 4.
module adc_seq_clk_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic conv_clk_o,
    output logic rise_o
);
    localparam int HALF = DIV / 2;
    localparam int PW   = $clog2(DIV);
    localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);
    localparam logic [PW-1:0] PH_HALF = PW'(HALF);

    logic [PW-1:0] ph;
    logic [PW-1:0] ph_nxt;
    logic          clk_q;

    // Next phase index, wrapping at the end of the period.
    always_comb begin
        ph_nxt = (ph == PH_LAST) ? '0 : ph + 1'b1;
    end

    assign rise_o = run & (ph_nxt == PH_HALF);

    // Phase counter and registered clock, both cleared while not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph    <= '0;
            clk_q <= 1'b0;
        end else begin
            ph    <= ph_nxt;
            clk_q <= (ph_nxt >= PH_HALF);
        end
    end

    assign conv_clk_o = clk_q;

    // Checker state: length of the current high and low runs, saturating.
    logic [PW:0] hi_len;
    logic [PW:0] lo_len;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_len <= '0;
            lo_len <= '0;
        end else if (clk_q) begin
            lo_len <= '0;
            if (hi_len != (PW+1)'(DIV)) hi_len <= hi_len + 1'b1;
        end else begin
            hi_len <= '0;
            if (lo_len != (PW+1)'(DIV)) lo_len <= lo_len + 1'b1;
        end
    end

    // R3
    high_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_q |-> (hi_len < (PW+1)'(HALF)));

    // R3
    low_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_q) |-> (lo_len >= (PW+1)'(HALF)));
endmodule

// File: rtl/adc_seq_tracker.sv
// Conversion tracker.
// Counts clock rising edges from each synchronized busy rise, saturating one
// above BITS. When busy falls it issues a done or error pulse by the count.
// A watchdog restarted by each strobe issues an error pulse if the conversion
// runs past TIMEOUT cycles and then silences that conversion's end.
// Assumes: busy_s is synchronized; start_i and rise_i are single-cycle.
module adc_seq_tracker
    import adc_seq_pkg::*;
#(
    parameter int BITS    = 17,
    parameter int TIMEOUT = 12288
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_s,
    input  logic start_i,
    input  logic rise_i,
    output logic done_o,
    output logic err_o
);
    localparam int ECW = $clog2(BITS + 2);
    localparam int TCW = $clog2(TIMEOUT);
    localparam logic [ECW-1:0] E_FULL = ECW'(BITS);
    localparam logic [ECW-1:0] E_SAT  = ECW'(BITS + 1);
    localparam logic [TCW-1:0] T_LAST = TCW'(TIMEOUT - 1);

    logic           busy_d;
    logic           b_rise;
    logic           b_fall;
    logic [ECW-1:0] ecnt;
    logic [TCW-1:0] tcnt;
    logic           t_active;
    logic           t_hit;
    logic           expire;
    verdict_e       verdict;
    logic           done_q;
    logic           err_q;

    // Delayed busy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_d <= 1'b0;
        else        busy_d <= busy_s;
    end

    assign b_rise = busy_s & ~busy_d;
    assign b_fall = ~busy_s & busy_d;
    assign expire = t_active && (tcnt == T_LAST) && !start_i && !b_fall;

    // Rising-edge counter, cleared at each new conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ecnt <= '0;
        else if (b_rise)                ecnt <= '0;
        else if (rise_i && ecnt != E_SAT) ecnt <= ecnt + 1'b1;
    end

    // Watchdog: restart at strobe, stop at conversion end or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt     <= '0;
            t_active <= 1'b0;
            t_hit    <= 1'b0;
        end else if (start_i) begin
            tcnt     <= '0;
            t_active <= 1'b1;
            t_hit    <= 1'b0;
        end else if (b_fall) begin
            t_active <= 1'b0;
        end else if (expire) begin
            t_active <= 1'b0;
            t_hit    <= 1'b1;
        end else begin
            if (t_active) tcnt <= tcnt + 1'b1;
            if (b_rise)   t_hit <= 1'b0;
        end
    end

    // Judge the conversion at its end or at watchdog expiry.
    always_comb begin
        verdict = VERDICT_NONE;
        if (b_fall && !t_hit)
            verdict = (ecnt == E_FULL) ? VERDICT_GOOD : VERDICT_BAD;
        else if (expire)
            verdict = VERDICT_BAD;
    end

    // Register the one-cycle result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= (verdict == VERDICT_GOOD);
            err_q  <= (verdict == VERDICT_BAD);
        end
    end

    assign done_o = done_q;
    assign err_o  = err_q;

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R6
    done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (ecnt == E_FULL));

    // R7
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q && err_q));

    // R8
    timeout_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_active |-> (tcnt <= T_LAST));
endmodule

// File: rtl/adc_conv_sequencer.sv
// Conversion clock sequencer, top level.
// Synchronizes busy, generates the acquisition strobe, runs the gated
// bit-decision clock only while busy is high and the strobe is low, and
// tracks each conversion for edge count, watchdog and overrun.
// Assumes: CONV_DIV even and >= 4; CONV_BITS*CONV_DIV fits inside a period
// for overrun-free operation; busy_in is asynchronous to clk.
module adc_conv_sequencer #(
    parameter int SAMPLE_PERIOD  = 128,
    parameter int ACQ_CYCLES     = 16,
    parameter int CONV_DIV       = 4,
    parameter int CONV_BITS      = 17,
    parameter int TIMEOUT_CYCLES = 12288,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_sel,
    input  logic busy_in,
    output logic sample_o,
    output logic conv_clk_o,
    output logic done_o,
    output logic err_o,
    output logic overrun_o
);
    logic busy_s;
    logic start;
    logic run;
    logic rise;

    adc_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (busy_in),
        .q     (busy_s)
    );

    adc_seq_sample_gen #(
        .BASE_PERIOD (SAMPLE_PERIOD),
        .ACQ_CYCLES  (ACQ_CYCLES)
    ) u_sample (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_sel  (rate_sel),
        .conv_busy (busy_s),
        .sample_o  (sample_o),
        .start_o   (start),
        .overrun_o (overrun_o)
    );

    // Divider runs only during a conversion and never under the strobe.
    assign run = busy_s & ~sample_o;

    adc_seq_clk_div #(.DIV(CONV_DIV)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .conv_clk_o (conv_clk_o),
        .rise_o     (rise)
    );

    adc_seq_tracker #(
        .BITS    (CONV_BITS),
        .TIMEOUT (TIMEOUT_CYCLES)
    ) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_s  (busy_s),
        .start_i (start),
        .rise_i  (rise),
        .done_o  (done_o),
        .err_o   (err_o)
    );

    // R5
    sample_clk_sep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> !conv_clk_o);

    // R5
    sample_fall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sample_o) |=> !conv_clk_o);

    // R2
    idle_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_s |=> !$rose(conv_clk_o));
endmodule

// File: tb/adc_conv_sequencer_test.sv
module adc_conv_sequencer_test;
    localparam int PER  = 128;
    localparam int ACQ  = 16;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;
    localparam int BITS = 17;
    localparam int TMO  = 12288;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rate_sel = 1'b0;
    logic busy_in = 1'b0;
    logic sample_o, conv_clk_o, done_o, err_o, overrun_o;

    always #5 clk = ~clk;

    adc_conv_sequencer uut (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .busy_in(busy_in),
        .sample_o(sample_o), .conv_clk_o(conv_clk_o), .done_o(done_o),
        .err_o(err_o), .overrun_o(overrun_o)
    );

    int n_run = 0, n_fail = 0, cyc = 0;
    int n_rise = 0, n_done = 0, n_err = 0;
    int last_srise = -1, srise_per = 0, rise_cyc = 0, fall_cyc = 0, err_cyc = 0;
    int v_sep = 0, v_shape = 0, v_width = 0;
    bit fall_ok = 0, reported = 0;
    logic s_p = 0, c_p = 0, d_p = 0, e_p = 0;

    function automatic int exp_period(input bit r);
        return r ? 2 * PER : PER;
    endfunction

    function automatic bit exp_good(input int k);
        return k == BITS;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        end
    endtask

    // Monitor: edges, pulse widths and shape violations, sampled at negedge.
    always @(negedge clk) begin
        cyc++;
        if (sample_o && !s_p) begin
            if (last_srise >= 0) srise_per = cyc - last_srise;
            last_srise = cyc;
        end
        if (sample_o && conv_clk_o) v_sep++;
        if (conv_clk_o && !c_p) begin
            n_rise++;
            if (fall_ok && (cyc - fall_cyc) != HALF) v_shape++;
            rise_cyc = cyc;
        end
        if (!conv_clk_o && c_p) begin
            if (busy_in && (cyc - rise_cyc) != HALF) v_shape++;
            fall_cyc = cyc;
            fall_ok  = busy_in;
        end
        if (!busy_in) fall_ok = 0;
        if (done_o) begin
            if (!d_p) n_done++; else v_width++;
        end
        if (err_o) begin
            if (!e_p) begin n_err++; err_cyc = cyc; end
            else v_width++;
        end
        s_p = sample_o; c_p = conv_clk_o; d_p = done_o; e_p = err_o;
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_rise();
        do tick(); while (sample_o);
        do tick(); while (!sample_o);
    endtask

    task automatic check_rate(input bit r);
        int w;
        rate_sel = r;
        wait_rise();
        wait_rise();
        chk(srise_per == exp_period(r), "R1 period", srise_per, exp_period(r));
        w = 0;
        while (sample_o) begin w++; tick(); end
        chk(w == ACQ, "R1 width", w, ACQ);
    endtask

    task automatic do_conv(input int k, input int dly);
        int nr0, nr1, c0, d0, e0;
        wait_rise();
        do tick(); while (sample_o);
        nr0 = n_rise;
        repeat (dly) tick();
        chk(n_rise == nr0, "R2 idle clock", n_rise - nr0, 0);
        busy_in = 1'b1;
        c0 = cyc;
        do tick(); while (n_rise == nr0);
        chk(rise_cyc - c0 == 2 + HALF, "R3 first edge", rise_cyc - c0, 2 + HALF);
        while (n_rise - nr0 < k) tick();
        busy_in = 1'b0;
        d0 = n_done; e0 = n_err;
        repeat (5) tick();
        chk(conv_clk_o == 1'b0, "R4 stop", conv_clk_o, 0);
        nr1 = n_rise;
        repeat (15) tick();
        chk(n_rise == nr1, "R4 no edge", n_rise - nr1, 0);
        chk(n_done - d0 == int'(exp_good(k)), "R6 done", n_done - d0, int'(exp_good(k)));
        chk(n_err - e0 == int'(!exp_good(k)), "R7 err", n_err - e0, int'(!exp_good(k)));
    endtask

    initial begin
        int t_r, d0, e0, k, dly;
        void'($urandom(32'h1F2E3D4C));
        rst_n = 1'b0;
        repeat (4) tick();
        chk({sample_o, conv_clk_o, done_o, err_o, overrun_o} == 5'b0, "R10 reset",
            int'({sample_o, conv_clk_o, done_o, err_o, overrun_o}), 0);
        rst_n = 1'b1;

        check_rate(1'b0);
        check_rate(1'b1);
        check_rate(1'b0);

        do_conv(17, 0);
        do_conv(16, 5);
        do_conv(18, 3);
        do_conv(1, 0);

        for (int i = 0; i < 16; i++) begin
            if (i % 4 == 0) rate_sel = 1'($urandom % 2);
            k   = 15 + int'($urandom % 5);
            dly = int'($urandom % 21);
            do_conv(k, dly);
        end
        chk(overrun_o == 1'b0, "R9 no spurious overrun", overrun_o, 0);

        // Conversion straddles a period boundary at the fast rate.
        rate_sel = 1'b0;
        wait_rise();
        do_conv(17, 60);
        chk(overrun_o == 1'b1, "R9 overrun set", overrun_o, 1);
        do tick(); while (!sample_o);
        chk(srise_per == 2 * PER, "R9 skipped strobe", srise_per, 2 * PER);
        repeat (300) tick();
        chk(overrun_o == 1'b1, "R9 sticky", overrun_o, 1);

        rst_n = 1'b0;
        repeat (3) tick();
        chk(overrun_o == 1'b0, "R10 overrun cleared", overrun_o, 0);
        rst_n = 1'b1;

        // Watchdog: busy never ends.
        wait_rise();
        t_r = last_srise;
        do tick(); while (sample_o);
        d0 = n_done; e0 = n_err;
        busy_in = 1'b1;
        do tick(); while (n_err == e0);
        chk(err_cyc - t_r == TMO, "R8 deadline", err_cyc - t_r, TMO);
        chk(overrun_o == 1'b1, "R9 overrun during stall", overrun_o, 1);
        repeat (40) tick();
        chk(n_err - e0 == 1, "R8 single pulse", n_err - e0, 1);
        busy_in = 1'b0;
        repeat (20) tick();
        chk(n_err - e0 == 1 && n_done == d0, "R8 end silenced", n_err - e0 + n_done - d0, 1);

        chk(v_sep == 0, "R5 clock under strobe", v_sep, 0);
        chk(v_shape == 0, "R3 phase lengths", v_shape, 0);
        chk(v_width == 0, "R6 R7 pulse width", v_width, 0);

        report();
        $finish;
    end

    initial begin
        #(150000 * 10);
        n_run++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual hung expected completion");
        report();
        $finish;
    end
endmodule